// File: doc/BRIEF.md
# Field Video DMA Address Generator

This block sits between a video capture front end and a bus-master write engine. For every captured Dword it produces the memory address the Dword is written to, reorders the bytes inside the Dword as configured, and issues a one-cycle write strobe. Each field starts at one of two base addresses, picked by the parity of the field. Each line starts one signed pitch after the start of the line before it, so a negative pitch stores the picture upside down.

The input is cropped to a programmed number of lines per field and Dwords per line. A guard address stops runaway writes. Depending on the violation mode, a hit at that address blocks the rest of the field, redirects the write to the field base, or only raises the flag. A region-change detector pulses an interrupt whenever a write lands in a different aligned memory region from the write before it. The region size is chosen by a 4-bit code.

Top module: `vdma_addr_gen`

## Requirements
- R1: A `field_start` pulse loads the field base from `cfg_base_odd` when `field_odd` is 1 and from `cfg_base_even` when it is 0. The first accepted Dword of the field is written at that base. Base bits [1:0] are treated as zero.
- R2: Within a line, each accepted Dword is written 4 bytes above the previous one. `wr_addr[1:0]` is always 00.
- R3: The first `line_start` after `field_start` starts at the field base. Each later `line_start` starts at the previous line start plus `cfg_pitch`, read as a signed 32-bit value. A negative pitch walks down through memory.
- R4: `cfg_swap` selects the byte order of `wr_data`, with input bytes written 3210 (byte 3 = bits [31:24]). 00 passes the Dword unchanged. 01 gives 2301. 10 gives 0123. 11 passes the Dword unchanged.
- R5: Only the first `cfg_lines` lines after a `field_start` produce writes. Later lines of that field produce none.
- R6: Only the first `cfg_pixels` `pix_valid` cycles of a line produce writes. Later ones in that line produce none.
- R7: With `cfg_pv_mode[0]`=1, a write whose address equals `cfg_guard` (bits [1:0] treated as zero) is dropped and sets `prot_viol`. Every later write of the same field is dropped. The next field writes normally.
- R8: With `cfg_pv_mode`=10, a guard hit sets `prot_viol` and the write goes to the field base instead. Following writes continue 4 bytes above that.
- R9: With `cfg_pv_mode`=00, a guard hit sets `prot_viol` and the write goes ahead unchanged. `prot_viol` stays set until reset.
- R10: With `cfg_limit` = n (1 to 15), `limit_irq` pulses together with any write whose address lies in a different aligned 2^(n+5)-byte region from the previous write. Code 0 gives no pulse. The first write after reset gives no pulse.
- R11: `wr_en`, `wr_addr`, `wr_data` and `limit_irq` for a Dword appear one clock after its `pix_valid` cycle. A `pix_valid` in the same cycle as `field_start` or `line_start` is ignored.
- R12: After reset, `wr_en`, `wr_addr`, `wr_data`, `limit_irq` and `prot_viol` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base_odd | input | 32 | Field base for odd fields |
| cfg_base_even | input | 32 | Field base for even fields |
| cfg_pitch | input | 32 | Signed distance between line starts |
| cfg_guard | input | 32 | Guard address, bits [1:0] ignored |
| cfg_limit | input | 4 | Region size code, 0 = off |
| cfg_pv_mode | input | 2 | Guard-hit handling: bit 0 block, bit 1 wrap |
| cfg_swap | input | 2 | Byte order select |
| cfg_lines | input | 12 | Lines accepted per field |
| cfg_pixels | input | 12 | Dwords accepted per line |
| field_start | input | 1 | Field start pulse |
| field_odd | input | 1 | Parity of the starting field |
| line_start | input | 1 | Line start pulse |
| pix_valid | input | 1 | Input Dword valid |
| pix_data | input | 32 | Input Dword |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Reordered Dword |
| limit_irq | output | 1 | Region-change pulse |
| prot_viol | output | 1 | Sticky guard-hit flag |

## Verification
Every write result (`wr_en`, `wr_addr`, `wr_data`, `limit_irq`) comes from the register stage, so it is due exactly one clock after the `pix_valid` cycle. `prot_viol` rises at that same edge. The bench drives each Dword at a falling edge and reads all outputs at the next falling edge, so exactly one rising edge lies between stimulus and sample. Dwords are sent with an idle cycle between them. A dropped Dword therefore shows up as `wr_en` low at that sample and cannot be confused with the write of a neighbouring Dword.

// File: rtl/vdma_pkg.sv
// Shared constants and types for the field video DMA address generator.
// Assumes a fixed 32-bit Dword data path.
package vdma_pkg;
    localparam int DWORD_W     = 32;
    localparam int DWORD_BYTES = DWORD_W / 8;

    typedef enum logic [1:0] {
        SWAP_NONE = 2'b00,
        SWAP_HALF = 2'b01,
        SWAP_FULL = 2'b10,
        SWAP_RSVD = 2'b11
    } swap_mode_t;
endpackage

// File: rtl/vdma_byte_swap.sv
// Combinational byte reorder of one Dword.
// Assumes a 4-byte Dword. The reserved mode passes data unchanged.
module vdma_byte_swap
    import vdma_pkg::*;
(
    input  logic [1:0]         mode,
    input  logic [DWORD_W-1:0] din,
    output logic [DWORD_W-1:0] dout
);
    logic [DWORD_W-1:0] half_sw;
    logic [DWORD_W-1:0] full_sw;

    // Build both reordered variants, one byte lane at a time.
    for (genvar b = 0; b < DWORD_BYTES; b++) begin : g_lane
        assign half_sw[8*b +: 8] = din[8*(b ^ 1) +: 8];
        assign full_sw[8*b +: 8] = din[8*(DWORD_BYTES-1-b) +: 8];
    end

    // Pick the variant that the mode asks for.
    always_comb begin
        unique case (swap_mode_t'(mode))
            SWAP_HALF: dout = half_sw;
            SWAP_FULL: dout = full_sw;
            default:   dout = din;
        endcase
    end
endmodule

// File: rtl/vdma_crop_ctrl.sv
// Counts lines per field and Dwords per line, and accepts a Dword only
// inside the programmed window. Assumes single-cycle strobes. A Dword in
// the same cycle as a field or line start is ignored.
module vdma_crop_ctrl #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_lines,
    input  logic [CNT_W-1:0] cfg_pixels,
    input  logic             field_start,
    input  logic             line_start,
    input  logic             pix_valid,
    output logic             line_first,
    output logic             accept
);
    localparam int CW = CNT_W + 1;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [CW-1:0] line_cnt;
    logic [CW-1:0] pix_cnt;
    logic          line_ok;
    logic          pix_seen;

    assign pix_seen   = pix_valid && !field_start && !line_start && line_ok;
    assign line_first = (line_cnt == '0);
    assign accept     = pix_seen && (pix_cnt < {1'b0, cfg_pixels});

    // Line counter and line window: cleared per field, advanced per line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt <= '0;
            line_ok  <= 1'b0;
        end else if (field_start) begin
            line_cnt <= '0;
            line_ok  <= 1'b0;
        end else if (line_start) begin
            line_ok  <= (line_cnt < {1'b0, cfg_lines});
            if (line_cnt != CMAX) line_cnt <= line_cnt + 1'b1;
        end
    end

    // Dword counter: cleared at each line or field, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || field_start || line_start) begin
            pix_cnt <= '0;
        end else if (pix_seen && pix_cnt != CMAX) begin
            pix_cnt <= pix_cnt + 1'b1;
        end
    end

    // R5: a field start leaves no line open and the line count at zero.
    assert_field_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> (line_cnt == '0 && !line_ok));
endmodule

// File: rtl/vdma_addr_unit.sv
// Keeps the field base, the line start and the running write address.
// Applies the guard-address handling. Assumes Dword-aligned addressing,
// with base and guard bits [1:0] forced to zero.
module vdma_addr_unit #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base_odd,
    input  logic [ADDR_W-1:0] cfg_base_even,
    input  logic [ADDR_W-1:0] cfg_pitch,
    input  logic [ADDR_W-1:0] cfg_guard,
    input  logic [1:0]        cfg_pv_mode,
    input  logic              field_start,
    input  logic              field_odd,
    input  logic              line_start,
    input  logic              line_first,
    input  logic              accept,
    output logic              wr_go,
    output logic [ADDR_W-1:0] wr_addr_c,
    output logic              viol
);
    localparam logic [ADDR_W-1:0] ALIGN = {{(ADDR_W-2){1'b1}}, 2'b00};
    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(4);

    logic [ADDR_W-1:0] field_base;
    logic [ADDR_W-1:0] line_addr;
    logic [ADDR_W-1:0] run_addr;
    logic [ADDR_W-1:0] next_line;
    logic              blocked;
    logic              hit;
    logic              try_wr;

    assign next_line = line_first ? field_base : line_addr + cfg_pitch;
    assign try_wr    = accept && !blocked;
    assign hit       = try_wr && (run_addr == (cfg_guard & ALIGN));
    assign wr_go     = try_wr && !(hit && cfg_pv_mode[0]);
    assign wr_addr_c = (hit && cfg_pv_mode == 2'b10) ? field_base : run_addr;

    // Address state: load per field, step per line, advance per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_base <= '0;
            line_addr  <= '0;
            run_addr   <= '0;
            blocked    <= 1'b0;
        end else if (field_start) begin
            field_base <= (field_odd ? cfg_base_odd : cfg_base_even) & ALIGN;
            line_addr  <= (field_odd ? cfg_base_odd : cfg_base_even) & ALIGN;
            run_addr   <= (field_odd ? cfg_base_odd : cfg_base_even) & ALIGN;
            blocked    <= 1'b0;
        end else if (line_start) begin
            line_addr  <= next_line;
            run_addr   <= next_line;
        end else if (try_wr) begin
            if (hit && cfg_pv_mode[0]) blocked <= 1'b1;
            else                       run_addr <= wr_addr_c + STEP;
        end
    end

    // Sticky violation flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   viol <= 1'b0;
        else if (hit) viol <= 1'b1;
    end

    // R9: the violation flag never falls outside reset.
    assert_viol_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol);
    // R7: a blocked field always comes with the flag raised.
    assert_block_flagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> viol);
endmodule

// File: rtl/vdma_limit_det.sv
// Pulses an interrupt when a write lands in a different aligned region
// from the previous write. The region size is 2^(code+MIN_LOG2) bytes.
// Code 0 disables the pulse. Assumes MIN_LOG2 + 2^LIMIT_W - 1 < ADDR_W.
module vdma_limit_det #(
    parameter int ADDR_W   = 32,
    parameter int LIMIT_W  = 4,
    parameter int MIN_LOG2 = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LIMIT_W-1:0] code,
    input  logic               wr_go,
    input  logic [ADDR_W-1:0]  addr,
    output logic               irq
);
    localparam int SH_W = $clog2(ADDR_W);

    logic [ADDR_W-1:0] prev_addr;
    logic              have_prev;
    logic [SH_W-1:0]   shift;
    logic [ADDR_W-1:0] region_mask;
    logic              moved;

    assign shift       = SH_W'(code) + SH_W'(MIN_LOG2);
    assign region_mask = ~((ADDR_W'(1) << shift) - ADDR_W'(1));
    assign moved       = ((addr ^ prev_addr) & region_mask) != '0;

    // Remember the last write and flag a region change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_addr <= '0;
            have_prev <= 1'b0;
            irq       <= 1'b0;
        end else begin
            irq <= wr_go && have_prev && (code != '0) && moved;
            if (wr_go) begin
                prev_addr <= addr;
                have_prev <= 1'b1;
            end
        end
    end

    // R10: no pulse follows a cycle with the interrupt code at zero.
    assert_code_zero_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(code) != '0);
endmodule

// File: rtl/vdma_addr_gen.sv
// Field video DMA address generator: crop window, address walk with
// signed pitch, guard address, region-change interrupt and byte reorder.
// Assumes single-cycle strobes. Write results are registered one clock
// after the accepted Dword.
module vdma_addr_gen #(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 12,
    parameter int LIMIT_W  = 4,
    parameter int MIN_LOG2 = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cfg_base_odd,
    input  logic [ADDR_W-1:0]  cfg_base_even,
    input  logic [ADDR_W-1:0]  cfg_pitch,
    input  logic [ADDR_W-1:0]  cfg_guard,
    input  logic [LIMIT_W-1:0] cfg_limit,
    input  logic [1:0]         cfg_pv_mode,
    input  logic [1:0]         cfg_swap,
    input  logic [CNT_W-1:0]   cfg_lines,
    input  logic [CNT_W-1:0]   cfg_pixels,
    input  logic               field_start,
    input  logic               field_odd,
    input  logic               line_start,
    input  logic               pix_valid,
    input  logic [31:0]        pix_data,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [31:0]        wr_data,
    output logic               limit_irq,
    output logic               prot_viol
);
    logic              line_first;
    logic              accept;
    logic              wr_go;
    logic [ADDR_W-1:0] wr_addr_c;
    logic [31:0]       swapped;

    vdma_crop_ctrl #(.CNT_W(CNT_W)) u_crop (
        .clk(clk), .rst_n(rst_n),
        .cfg_lines(cfg_lines), .cfg_pixels(cfg_pixels),
        .field_start(field_start), .line_start(line_start),
        .pix_valid(pix_valid),
        .line_first(line_first), .accept(accept)
    );

    vdma_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .cfg_base_odd(cfg_base_odd), .cfg_base_even(cfg_base_even),
        .cfg_pitch(cfg_pitch), .cfg_guard(cfg_guard),
        .cfg_pv_mode(cfg_pv_mode),
        .field_start(field_start), .field_odd(field_odd),
        .line_start(line_start), .line_first(line_first),
        .accept(accept),
        .wr_go(wr_go), .wr_addr_c(wr_addr_c), .viol(prot_viol)
    );

    vdma_limit_det #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .MIN_LOG2(MIN_LOG2)) u_limit (
        .clk(clk), .rst_n(rst_n),
        .code(cfg_limit), .wr_go(wr_go), .addr(wr_addr_c),
        .irq(limit_irq)
    );

    vdma_byte_swap u_swap (
        .mode(cfg_swap), .din(pix_data), .dout(swapped)
    );

    // Output register stage for the write strobe, address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= wr_go;
            if (wr_go) begin
                wr_addr <= wr_addr_c;
                wr_data <= swapped;
            end
        end
    end

    // R2: every write address is Dword aligned.
    assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_addr[1:0] == 2'b00);
    // R11: a write strobe always follows a valid input Dword by one clock.
    assert_write_follows_pix_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(pix_valid));
endmodule

// File: tb/test_vdma_addr_gen.sv
module test_vdma_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_base_odd = '0, cfg_base_even = '0, cfg_pitch = '0;
    logic [31:0] cfg_guard = 32'hFFFF_FFF0;
    logic [3:0]  cfg_limit = '0;
    logic [1:0]  cfg_pv_mode = '0, cfg_swap = '0;
    logic [11:0] cfg_lines = 12'd8, cfg_pixels = 12'd16;
    logic        field_start = 1'b0, field_odd = 1'b0, line_start = 1'b0, pix_valid = 1'b0;
    logic [31:0] pix_data = '0;
    logic        wr_en, limit_irq, prot_viol;
    logic [31:0] wr_addr, wr_data;

    int n_chk = 0;
    int n_fail = 0;
    logic        o_en, o_irq, o_viol;
    logic [31:0] o_addr, o_data;

    always #5 clk = ~clk;

    vdma_addr_gen i_vdma_addr_gen (
        .clk(clk), .rst_n(rst_n),
        .cfg_base_odd(cfg_base_odd), .cfg_base_even(cfg_base_even),
        .cfg_pitch(cfg_pitch), .cfg_guard(cfg_guard), .cfg_limit(cfg_limit),
        .cfg_pv_mode(cfg_pv_mode), .cfg_swap(cfg_swap),
        .cfg_lines(cfg_lines), .cfg_pixels(cfg_pixels),
        .field_start(field_start), .field_odd(field_odd),
        .line_start(line_start), .pix_valid(pix_valid), .pix_data(pix_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .limit_irq(limit_irq), .prot_viol(prot_viol)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic new_field(input logic odd);
        @(negedge clk); field_start = 1'b1; field_odd = odd;
        @(negedge clk); field_start = 1'b0;
    endtask

    task automatic new_line();
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
    endtask

    // Drive one Dword and sample the registered result one clock later.
    task automatic send(input logic [31:0] d);
        @(negedge clk); pix_valid = 1'b1; pix_data = d;
        @(negedge clk); pix_valid = 1'b0;
        o_en = wr_en; o_addr = wr_addr; o_data = wr_data; o_irq = limit_irq; o_viol = prot_viol;
    endtask

    task automatic send_chk(input string tag, input logic en, input logic [31:0] addr);
        send(32'h0);
        chk({tag, " wr_en"}, 32'(o_en), 32'(en));
        if (en) chk({tag, " wr_addr"}, o_addr, addr);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R12 wr_en", 32'(wr_en), 0);
        chk("R12 wr_addr", wr_addr, 0);
        chk("R12 wr_data", wr_data, 0);
        chk("R12 limit_irq", 32'(limit_irq), 0);
        chk("R12 prot_viol", 32'(prot_viol), 0);
    endtask

    task automatic t_parity();
        cfg_base_odd = 32'h0000_1000; cfg_base_even = 32'h2000_0003; cfg_pitch = 32'h100;
        new_field(1'b1); new_line();
        send_chk("R1 odd base", 1'b1, 32'h1000);
        send_chk("R2 step 1", 1'b1, 32'h1004);
        send_chk("R2 step 2", 1'b1, 32'h1008);
        new_field(1'b0);
        @(negedge clk); line_start = 1'b1; pix_valid = 1'b1;
        @(negedge clk); line_start = 1'b0; pix_valid = 1'b0;
        chk("R11 pix with line_start ignored", 32'(wr_en), 0);
        send_chk("R1 even base low bits cleared", 1'b1, 32'h2000_0000);
        new_line();
        send_chk("R3 second line", 1'b1, 32'h2000_0100);
    endtask

    task automatic t_pitch();
        cfg_base_odd = 32'h8000; cfg_pitch = 32'h40;
        new_field(1'b1);
        for (int i = 0; i < 3; i++) begin
            new_line();
            send_chk("R3 positive pitch", 1'b1, 32'h8000 + 32'(i) * 32'h40);
        end
        cfg_base_odd = 32'h9000; cfg_pitch = 32'hFFFF_FFC0;
        new_field(1'b1);
        for (int i = 0; i < 3; i++) begin
            new_line();
            send_chk("R3 negative pitch", 1'b1, 32'h9000 - 32'(i) * 32'h40);
        end
    endtask

    task automatic t_swap();
        logic [31:0] exp_d [4];
        exp_d[0] = 32'h4433_2211; exp_d[1] = 32'h3344_1122;
        exp_d[2] = 32'h1122_3344; exp_d[3] = 32'h4433_2211;
        cfg_base_odd = 32'h100; cfg_pitch = 32'h100;
        new_field(1'b1); new_line();
        for (int m = 0; m < 4; m++) begin
            cfg_swap = 2'(m);
            send(32'h4433_2211);
            chk($sformatf("R4 swap mode %0d", m), o_data, exp_d[m]);
        end
        cfg_swap = 2'b00;
    endtask

    task automatic t_crop_lines();
        cfg_base_odd = 32'h3000; cfg_pitch = 32'h100; cfg_lines = 12'd2;
        new_field(1'b1);
        new_line(); send_chk("R5 line 1", 1'b1, 32'h3000);
        new_line(); send_chk("R5 line 2", 1'b1, 32'h3100);
        new_line(); send_chk("R5 line 3 cut", 1'b0, 32'h0);
        new_line(); send_chk("R5 line 4 cut", 1'b0, 32'h0);
        new_field(1'b1);
        new_line(); send_chk("R5 next field line 1", 1'b1, 32'h3000);
        cfg_lines = 12'd8;
    endtask

    task automatic t_crop_pix();
        cfg_base_odd = 32'h5000; cfg_pitch = 32'h80; cfg_pixels = 12'd3;
        new_field(1'b1); new_line();
        send_chk("R6 dword 1", 1'b1, 32'h5000);
        send_chk("R6 dword 2", 1'b1, 32'h5004);
        send_chk("R6 dword 3", 1'b1, 32'h5008);
        send_chk("R6 dword 4 cut", 1'b0, 32'h0);
        new_line();
        send_chk("R6 new line restarts", 1'b1, 32'h5080);
        cfg_pixels = 12'd16;
    endtask

    task automatic t_prot_block();
        do_reset();
        cfg_base_odd = 32'h4000; cfg_pitch = 32'h100; cfg_guard = 32'h4008; cfg_pv_mode = 2'b01;
        new_field(1'b1); new_line();
        send_chk("R7 before guard", 1'b1, 32'h4000);
        send_chk("R7 before guard 2", 1'b1, 32'h4004);
        chk("R7 flag low before hit", 32'(o_viol), 0);
        send_chk("R7 hit dropped", 1'b0, 32'h0);
        chk("R7 flag set", 32'(o_viol), 1);
        send_chk("R7 rest of line dropped", 1'b0, 32'h0);
        new_line(); send_chk("R7 next line dropped", 1'b0, 32'h0);
        new_field(1'b1); new_line();
        send_chk("R7 next field resumes", 1'b1, 32'h4000);
        chk("R9 flag still set", 32'(o_viol), 1);
    endtask

    task automatic t_prot_wrap();
        do_reset();
        cfg_base_odd = 32'h4000; cfg_pitch = 32'h100; cfg_guard = 32'h400B; cfg_pv_mode = 2'b10;
        new_field(1'b1); new_line();
        send_chk("R8 write 1", 1'b1, 32'h4000);
        send_chk("R8 write 2", 1'b1, 32'h4004);
        send_chk("R8 hit wraps to base", 1'b1, 32'h4000);
        chk("R8 flag set", 32'(o_viol), 1);
        send_chk("R8 continues after wrap", 1'b1, 32'h4004);
    endtask

    task automatic t_prot_pass();
        do_reset();
        cfg_base_odd = 32'h4000; cfg_pitch = 32'h100; cfg_guard = 32'h4004; cfg_pv_mode = 2'b00;
        new_field(1'b1); new_line();
        send_chk("R9 write 1", 1'b1, 32'h4000);
        send_chk("R9 hit written", 1'b1, 32'h4004);
        chk("R9 flag set", 32'(o_viol), 1);
        send_chk("R9 after hit", 1'b1, 32'h4008);
        new_field(1'b1);
        chk("R9 flag kept across field", 32'(prot_viol), 1);
        do_reset();
        @(negedge clk);
        chk("R12 flag cleared by reset", 32'(prot_viol), 0);
        cfg_guard = 32'hFFFF_FFF0;
    endtask

    task automatic lim(input string tag, input logic [31:0] addr, input logic irq);
        send(32'h0);
        chk({tag, " addr"}, o_addr, addr);
        chk({tag, " irq"}, 32'(o_irq), 32'(irq));
    endtask

    task automatic t_limit();
        do_reset();
        cfg_base_odd = 32'h1038; cfg_pitch = 32'h100; cfg_limit = 4'd1;
        new_field(1'b1); new_line();
        lim("R10 first write no pulse", 32'h1038, 1'b0);
        lim("R10 same region", 32'h103C, 1'b0);
        lim("R10 64B boundary", 32'h1040, 1'b1);
        lim("R10 after boundary", 32'h1044, 1'b0);
        cfg_limit = 4'd0;
        new_field(1'b1); new_line();
        lim("R10 code 0 a", 32'h1038, 1'b0);
        lim("R10 code 0 b", 32'h103C, 1'b0);
        lim("R10 code 0 c", 32'h1040, 1'b0);
        cfg_limit = 4'd3; cfg_base_odd = 32'h10F8;
        new_field(1'b1); new_line();
        lim("R10 256B same region", 32'h10F8, 1'b0);
        lim("R10 256B same region 2", 32'h10FC, 1'b0);
        lim("R10 256B boundary", 32'h1100, 1'b1);
        cfg_limit = 4'd0;
    endtask

    initial begin
        t_reset();
        t_parity();
        t_pitch();
        t_swap();
        t_crop_lines();
        t_crop_pix();
        t_prot_block();
        t_prot_wrap();
        t_prot_pass();
        t_limit();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule